// File: doc/BRIEF.md
# Sub-CPU Window Bus Bridge

This bridge sits between the main processor and a window that opens onto the address space of a secondary processor. Each main-CPU access carries an offset inside the window, a read/write flag and a byte/word size. The bridge decides whether the access may proceed and which target it reaches. The targets are an 8 KB shared RAM, the port of an FM sound chip, and a miscellaneous page. That page holds a one-bit bank register and a forbidden video region. The RAM array, the sound chip and the bank register live outside the bridge. The bridge only drives their strobes, index and data byte, and it takes their read bytes back.

Accesses go through only while the secondary processor has handed over its bus. At all other times, reads return the open-bus value and writes vanish. Touching the video region asks the system to halt, unless a force-acknowledge option is set. A byte write into the shared RAM also reports a fixed bus latency penalty to the main CPU's timing logic.

The window offset is 15 bits wide, so the upper and lower 32 KB halves of the 64 KB window mirror each other. Strobes are combinational pulses in the request cycle. Read data comes back registered, one cycle after the request.

Top module: `subwin_bridge`

## Requirements
- R1: An access takes effect only when `bus_state` equals 2'b11. With any other value there is no strobe, no `halt_req` and no latency, and the shared RAM contents stay unchanged.
- R2: A read made while the bus is not granted returns the open-bus value. A word read returns the held 16-bit value. A byte read returns one byte of it copied onto both lanes: bits 15:8 when the address is even, bits 7:0 when it is odd.
- R3: Address bits 14:13 pick the target: 2'b10 is the FM port (port number = address bits 1:0), 2'b11 is the miscellaneous page, and 2'b00/2'b01 are the shared RAM indexed by address bits 12:0.
- R4: A read from the RAM or the FM port returns the target byte on both `rsp_rdata[15:8]` and `rsp_rdata[7:0]`, with `rsp_valid` high in the cycle after the request.
- R5: A write to the RAM or the FM port sends `req_wdata[15:8]` for a word access and `req_wdata[7:0]` for a byte access.
- R6: In the miscellaneous page, address bits 14:8 = 0x60 pulse `bank_wr`. `bank_bit` is `req_wdata[0]` for a byte write and `req_wdata[8]` for a word write.
- R7: An access to address bits 14:8 = 0x7F pulses `halt_req` in the same cycle unless `force_ack` is high. A read there returns 16'hFFFF.
- R8: A read from any other miscellaneous-page address, the bank page included, returns 16'hFFFF. A write there has no effect.
- R9: A granted byte write to the RAM drives `latency_add` = 8 in the request cycle. Every other access drives 0.
- R10: At most one target strobe is high, only in the request cycle, and none is high when there is no request.
- R11: After reset `rsp_valid` is low and the held open-bus value is 16'h0000. Every write's data and every read's returned word become the new held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_state | input | 2 | Secondary bus request/grant state; 2'b11 = granted |
| force_ack | input | 1 | Suppresses the halt request for the video region |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 15 | Offset inside the window |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after a read request) |
| rsp_rdata | output | 16 | Read data |
| halt_req | output | 1 | Halt request pulse for a forbidden access |
| latency_add | output | 4 | Extra master cycles charged to this access |
| ram_rd | output | 1 | Shared RAM read strobe |
| ram_wr | output | 1 | Shared RAM write strobe |
| ram_addr | output | 13 | Shared RAM byte index |
| ram_wdata | output | 8 | Shared RAM write byte |
| ram_rdata | input | 8 | Shared RAM read byte (combinational) |
| fm_rd | output | 1 | FM port read strobe |
| fm_wr | output | 1 | FM port write strobe |
| fm_port | output | 2 | FM port number |
| fm_wdata | output | 8 | FM write byte |
| fm_rdata | input | 8 | FM read byte (combinational) |
| bank_wr | output | 1 | Bank register write strobe |
| bank_bit | output | 1 | Bank register write value |

## Verification
The main decode is driven with every target under both byte and word sizes. Mirrored RAM offsets, where bit 13 is set, show that bits 14:13 pick the target and bits 12:0 index the RAM. Writes whose high and low data bytes differ show which lane feeds the RAM, the FM port and the bank bit. Ungranted reads come after ungranted writes with distinct bytes, at even and odd offsets, which separates a correct open-bus lane choice from a swapped one. A RAM read after an ungranted write shows at the ports that the dropped write left the RAM untouched.

// File: rtl/subwin_pkg.sv
package subwin_pkg;
    typedef enum logic [2:0] {
        TGT_NONE,   // no request, or bus not granted
        TGT_RAM,
        TGT_FM,
        TGT_BANK,
        TGT_VIDEO,
        TGT_SPARE   // rest of the miscellaneous page
    } subwin_tgt_e;
endpackage

// File: rtl/subwin_decode.sv
module subwin_decode
    import subwin_pkg::*;
#(
    parameter logic [1:0] GRANT_CODE = 2'b11,
    parameter logic [6:0] BANK_PAGE  = 7'h60,
    parameter logic [6:0] VIDEO_PAGE = 7'h7F
) (
    input  logic        req_valid,
    input  logic [1:0]  bus_state,
    input  logic [6:0]  page,        // window offset bits 14:8
    output subwin_tgt_e tgt
);
    logic [1:0] sel;

    always_comb begin
        sel = page[6:5];             // offset bits 14:13
        tgt = TGT_NONE;
        if (req_valid && (bus_state == GRANT_CODE)) begin
            unique case (sel)
                2'b10:   tgt = TGT_FM;
                2'b11: begin
                    if (page == BANK_PAGE)       tgt = TGT_BANK;
                    else if (page == VIDEO_PAGE) tgt = TGT_VIDEO;
                    else                         tgt = TGT_SPARE;
                end
                default: tgt = TGT_RAM;
            endcase
        end
    end
endmodule

// File: rtl/subwin_rdlanes.sv
module subwin_rdlanes
    import subwin_pkg::*;
#(
    parameter int DW = 16
) (
    input  subwin_tgt_e     tgt,
    input  logic            req_word,
    input  logic            addr_lsb,
    input  logic [DW/2-1:0] ram_rdata,
    input  logic [DW/2-1:0] fm_rdata,
    input  logic [DW-1:0]   last_bus,
    output logic [DW-1:0]   rd_word
);
    localparam int BW = DW / 2;

    always_comb begin
        unique case (tgt)
            TGT_RAM:  rd_word = {2{ram_rdata}};
            TGT_FM:   rd_word = {2{fm_rdata}};
            TGT_BANK, TGT_VIDEO, TGT_SPARE:
                      rd_word = '1;
            default: begin   // open bus
                if (req_word)      rd_word = last_bus;
                else if (addr_lsb) rd_word = {2{last_bus[BW-1:0]}};
                else               rd_word = {2{last_bus[DW-1:BW]}};
            end
        endcase
    end
endmodule

// File: rtl/subwin_strobes.sv
module subwin_strobes
    import subwin_pkg::*;
#(
    parameter int DW          = 16,
    parameter int LAT_W       = 4,
    parameter int BYTE_WR_LAT = 8
) (
    input  subwin_tgt_e     tgt,
    input  logic            req_write,
    input  logic            req_word,
    input  logic            force_ack,
    input  logic [DW-1:0]   wdata,
    output logic [DW/2-1:0] wbyte,
    output logic            bank_bit,
    output logic            ram_rd,
    output logic            ram_wr,
    output logic            fm_rd,
    output logic            fm_wr,
    output logic            bank_wr,
    output logic            halt,
    output logic [LAT_W-1:0] latency
);
    localparam int BW = DW / 2;

    always_comb begin
        wbyte    = req_word ? wdata[DW-1:BW] : wdata[BW-1:0];
        bank_bit = req_word ? wdata[BW] : wdata[0];
        ram_rd   = (tgt == TGT_RAM)  && !req_write;
        ram_wr   = (tgt == TGT_RAM)  &&  req_write;
        fm_rd    = (tgt == TGT_FM)   && !req_write;
        fm_wr    = (tgt == TGT_FM)   &&  req_write;
        bank_wr  = (tgt == TGT_BANK) &&  req_write;
        halt     = (tgt == TGT_VIDEO) && !force_ack;
        latency  = ((tgt == TGT_RAM) && req_write && !req_word)
                   ? LAT_W'(BYTE_WR_LAT) : '0;
    end
endmodule

// File: rtl/subwin_bridge.sv
module subwin_bridge
    import subwin_pkg::*;
#(
    parameter int AW          = 15,
    parameter int DW          = 16,
    parameter int RAM_AW      = 13,
    parameter int FM_PW       = 2,
    parameter int LAT_W       = 4,
    parameter int BYTE_WR_LAT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_state,
    input  logic              force_ack,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              halt_req,
    output logic [LAT_W-1:0]  latency_add,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW/2-1:0]   ram_wdata,
    input  logic [DW/2-1:0]   ram_rdata,
    output logic              fm_rd,
    output logic              fm_wr,
    output logic [FM_PW-1:0]  fm_port,
    output logic [DW/2-1:0]   fm_wdata,
    input  logic [DW/2-1:0]   fm_rdata,
    output logic              bank_wr,
    output logic              bank_bit
);
    localparam int BW      = DW / 2;
    localparam int PAGE_LO = AW - 7;

    typedef struct packed {
        logic          rsp_valid;
        logic [DW-1:0] rsp_rdata;
        logic [DW-1:0] last_bus;
    } state_t;

    state_t          st_d, st_q;
    subwin_tgt_e     tgt;
    logic [DW-1:0]   rd_word;
    logic [BW-1:0]   wbyte;

    subwin_decode u_decode (
        .req_valid (req_valid),
        .bus_state (bus_state),
        .page      (req_addr[AW-1:PAGE_LO]),
        .tgt       (tgt)
    );

    subwin_rdlanes #(.DW(DW)) u_rdlanes (
        .tgt       (tgt),
        .req_word  (req_word),
        .addr_lsb  (req_addr[0]),
        .ram_rdata (ram_rdata),
        .fm_rdata  (fm_rdata),
        .last_bus  (st_q.last_bus),
        .rd_word   (rd_word)
    );

    subwin_strobes #(.DW(DW), .LAT_W(LAT_W), .BYTE_WR_LAT(BYTE_WR_LAT)) u_strobes (
        .tgt       (tgt),
        .req_write (req_write),
        .req_word  (req_word),
        .force_ack (force_ack),
        .wdata     (req_wdata),
        .wbyte     (wbyte),
        .bank_bit  (bank_bit),
        .ram_rd    (ram_rd),
        .ram_wr    (ram_wr),
        .fm_rd     (fm_rd),
        .fm_wr     (fm_wr),
        .bank_wr   (bank_wr),
        .halt      (halt_req),
        .latency   (latency_add)
    );

    assign ram_addr  = req_addr[RAM_AW-1:0];
    assign fm_port   = req_addr[FM_PW-1:0];
    assign ram_wdata = wbyte;
    assign fm_wdata  = wbyte;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        if (req_valid) begin
            if (req_write) begin
                st_d.last_bus  = req_wdata;
            end else begin
                st_d.rsp_rdata = rd_word;
                st_d.last_bus  = rd_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;

    assert_no_effect_ungranted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bus_state != 2'b11) |->
        !(ram_rd || ram_wr || fm_rd || fm_wr || bank_wr || halt_req || latency_add != '0));

    assert_rsp_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_stray_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    assert_lane_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && bus_state == 2'b11 && !req_addr[AW-1]) |=>
        (rsp_rdata[DW-1:BW] == rsp_rdata[BW-1:0]));

    assert_halt_only_video_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (!force_ack && req_addr[AW-1:PAGE_LO] == 7'h7F));

    assert_latency_byte_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (latency_add != '0) |-> (ram_wr && !req_word));

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd, ram_wr, fm_rd, fm_wr, bank_wr}));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(ram_rd || ram_wr || fm_rd || fm_wr || bank_wr || halt_req));
endmodule

// File: tb/subwin_bridge_test.sv
`timescale 1ns/1ps
module subwin_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_state = 2'b00;
    logic        force_ack = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        halt_req;
    logic [3:0]  latency_add;
    logic        ram_rd, ram_wr, fm_rd, fm_wr, bank_wr, bank_bit;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata, fm_wdata, fm_rdata;
    logic [1:0]  fm_port;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] exp_last = 16'h0000;
    logic [15:0] q_exp[$];
    string       q_tag[$];
    logic [7:0]  mem [256];

    always #2 clk = ~clk;

    subwin_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_state(bus_state), .force_ack(force_ack),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .halt_req(halt_req),
        .latency_add(latency_add),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .fm_rd(fm_rd), .fm_wr(fm_wr), .fm_port(fm_port),
        .fm_wdata(fm_wdata), .fm_rdata(fm_rdata),
        .bank_wr(bank_wr), .bank_bit(bank_bit)
    );

    // external target models
    always @(posedge clk) if (ram_wr) mem[ram_addr[7:0]] <= ram_wdata;
    assign ram_rdata = mem[ram_addr[7:0]];
    assign fm_rdata  = 8'hA0 | {6'b0, fm_port};

    function automatic logic [15:0] ob(input bit word, input logic [14:0] a);
        if (word)      return exp_last;
        else if (a[0]) return {2{exp_last[7:0]}};
        else           return {2{exp_last[15:8]}};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // mask order: {ram_rd, ram_wr, fm_rd, fm_wr, bank_wr, halt_req}
    task automatic access(input logic [1:0] st, input bit wr, input bit word,
                          input logic [14:0] a, input logic [15:0] wd, input bit fa,
                          input logic [5:0] mask, input logic [3:0] lat,
                          input logic [7:0] wb, input logic [15:0] rd, input string tag);
        logic [5:0] act;
        @(negedge clk);
        bus_state = st; force_ack = fa; req_valid = 1'b1; req_write = wr;
        req_word = word; req_addr = a; req_wdata = wd;
        #1;
        act = {ram_rd, ram_wr, fm_rd, fm_wr, bank_wr, halt_req};
        check({tag, " strobes"}, {28'b0, act}, {28'b0, mask});
        check({tag, " latency"}, {28'b0, latency_add}, {28'b0, lat});
        if (mask[5] || mask[4]) check({tag, " ram index"}, {19'b0, ram_addr}, {19'b0, a[12:0]});
        if (mask[3] || mask[2]) check({tag, " fm port"}, {30'b0, fm_port}, {30'b0, a[1:0]});
        if (mask[4]) check({tag, " ram byte"}, {24'b0, ram_wdata}, {24'b0, wb});
        if (mask[2]) check({tag, " fm byte"}, {24'b0, fm_wdata}, {24'b0, wb});
        if (mask[1]) check({tag, " bank bit"}, {31'b0, bank_bit}, {31'b0, wb[0]});
        if (wr) exp_last = wd;
        else begin
            q_exp.push_back(rd);
            q_tag.push_back(tag);
            exp_last = rd;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #1;
        check("R10 idle strobes",
              {26'b0, ram_rd, ram_wr, fm_rd, fm_wr, bank_wr, halt_req}, 32'h0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_exp.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4 unexpected response: actual %0h expected none", rsp_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check({t, " rdata"}, {16'b0, rsp_rdata}, {16'b0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        // R11/R2: first open-bus word read after reset
        access(2'b01, 0, 1, 15'h0000, 16'h0, 0, 6'b000000, 0, 8'h00, ob(1, 15'h0000), "R11 open bus after reset");
        // R1: ungranted write, then R2 lane choice
        access(2'b00, 1, 1, 15'h0010, 16'hBEEF, 0, 6'b000000, 0, 8'h00, 16'h0, "R1 ungranted word write");
        access(2'b10, 0, 0, 15'h0000, 16'h0, 0, 6'b000000, 0, 8'h00, ob(0, 15'h0000), "R2 open bus even byte");
        access(2'b01, 1, 0, 15'h0033, 16'h1234, 0, 6'b000000, 0, 8'h00, 16'h0, "R1 ungranted byte write");
        access(2'b10, 0, 0, 15'h0001, 16'h0, 0, 6'b000000, 0, 8'h00, ob(0, 15'h0001), "R2 open bus odd byte");
        access(2'b00, 0, 1, 15'h0000, 16'h0, 0, 6'b000000, 0, 8'h00, ob(1, 15'h0000), "R2 open bus word");
        // R3/R5/R9: RAM writes
        access(2'b11, 1, 0, 15'h0005, 16'hC33C, 0, 6'b010000, 4'd8, 8'h3C, 16'h0, "R9 R5 byte ram write");
        access(2'b11, 1, 1, 15'h2007, 16'h5AA5, 0, 6'b010000, 4'd0, 8'h5A, 16'h0, "R9 R5 word ram write mirror");
        // R4: RAM reads duplicated
        access(2'b11, 0, 1, 15'h0005, 16'h0, 0, 6'b100000, 0, 8'h00, 16'h3C3C, "R4 ram word read");
        access(2'b11, 0, 0, 15'h2007, 16'h0, 0, 6'b100000, 0, 8'h00, 16'h5A5A, "R3 ram byte read bit13");
        // FM
        access(2'b11, 1, 0, 15'h4002, 16'h8877, 0, 6'b000100, 0, 8'h77, 16'h0, "R5 fm byte write");
        access(2'b11, 1, 1, 15'h4001, 16'h9911, 0, 6'b000100, 0, 8'h99, 16'h0, "R5 fm word write");
        access(2'b11, 0, 1, 15'h4003, 16'h0, 0, 6'b001000, 0, 8'h00, 16'hA3A3, "R4 fm word read");
        access(2'b11, 0, 0, 15'h5FFE, 16'h0, 0, 6'b001000, 0, 8'h00, 16'hA2A2, "R3 fm byte read");
        // R6 bank
        access(2'b11, 1, 0, 15'h6000, 16'h0001, 0, 6'b000010, 0, 8'h01, 16'h0, "R6 bank byte 1");
        access(2'b11, 1, 0, 15'h6000, 16'h01FE, 0, 6'b000010, 0, 8'h00, 16'h0, "R6 bank byte 0");
        access(2'b11, 1, 1, 15'h6000, 16'h0100, 0, 6'b000010, 0, 8'h01, 16'h0, "R6 bank word 1");
        access(2'b11, 1, 1, 15'h6000, 16'h00FF, 0, 6'b000010, 0, 8'h00, 16'h0, "R6 bank word 0");
        // R7 video
        access(2'b11, 0, 0, 15'h7F00, 16'h0, 0, 6'b000001, 0, 8'h00, 16'hFFFF, "R7 video read halt");
        access(2'b11, 1, 1, 15'h7F10, 16'h1234, 0, 6'b000001, 0, 8'h00, 16'h0, "R7 video write halt");
        access(2'b11, 0, 1, 15'h7F02, 16'h0, 1, 6'b000000, 0, 8'h00, 16'hFFFF, "R7 video forced ack");
        // R8 rest of misc page
        access(2'b11, 0, 0, 15'h6100, 16'h0, 0, 6'b000000, 0, 8'h00, 16'hFFFF, "R8 misc byte read");
        access(2'b11, 0, 1, 15'h6001, 16'h0, 0, 6'b000000, 0, 8'h00, 16'hFFFF, "R8 bank page read");
        access(2'b11, 1, 0, 15'h6200, 16'h5555, 0, 6'b000000, 0, 8'h00, 16'h0, "R8 misc write dropped");
        // R1: ungranted RAM write leaves RAM unchanged
        access(2'b10, 1, 0, 15'h0005, 16'h00FF, 0, 6'b000000, 0, 8'h00, 16'h0, "R1 ungranted ram write");
        access(2'b11, 0, 1, 15'h0005, 16'h0, 0, 6'b100000, 0, 8'h00, 16'h3C3C, "R1 ram unchanged");
        access(2'b01, 0, 0, 15'h7F00, 16'h0, 0, 6'b000000, 0, 8'h00, ob(0, 15'h7F00), "R1 ungranted video no halt");
        idle();
        idle();
        repeat (2) @(negedge clk);
        check("R4 all responses seen", q_exp.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule